// File: doc/BRIEF.md
# Packet-Driven Pin Sequence Interpreter

This block runs a small pin-control program that reaches it as a byte stream split into fixed-size packets. A packet is acted on only when its first byte is the stream opcode 0xAB. Every later byte in that packet is a sub-command. A sub-command can change the levels of six output pins, change their output enables, wait for a number of microseconds, or sample the pins into a one-byte response. A further sub-command ends the program.

Writing the levels takes one fixed time slot of `SLOT_CLKS` clocks. Host software can therefore repeat the same level write to hold a pin for a known time. This is how a chip-select deassertion pulse of controlled length is built, all inside one packet and without a timer interface. The upstream source is stalled through `in_ready` while a slot or a wait is running.

By convention, pin 0 is chip select, pin 3 is the serial clock and pin 5 is the serial data output. Input pin D7 (`in_pins[1]`) carries serial data in.

Top module: `gseq_interp`

## Requirements
- R1: During and after reset, `pin_out` is 0x00, `pin_oe` is 0x00, `rsp_valid` is 0 and `in_ready` is 1.
- R2: A byte is accepted when `in_valid` and `in_ready` are both high. An accepted byte with `in_first` high starts a packet. If that byte is not 0xAB, the whole packet is discarded: no pin changes and no responses.
- R3: A sub-command of the form 10xxxxxx copies bits 5:0 to `pin_out`, visible in the cycle after acceptance. `pin_out` changes at no other time.
- R4: A level write occupies `SLOT_CLKS` cycles. `in_ready` stays low for `SLOT_CLKS`-1 cycles after the write is accepted, so back-to-back level writes update the pins once per slot.
- R5: A sub-command of the form 01xxxxxx copies bits 5:0 to `pin_oe` in the next cycle, without stalling. `pin_oe` changes at no other time.
- R6: A sub-command 11nnnnnn holds `in_ready` low for n×`CLKS_PER_US`-1 cycles after acceptance. When n=0 there is no stall.
- R7: A sub-command 000xxxxx raises `rsp_valid` for one cycle, in the cycle after acceptance. `rsp_data` is {`in_pins[1:0]`, `pin_out[5:0]`} as they were when the sub-command was accepted.
- R8: A sub-command 001xxxxx ends interpretation. The remaining bytes of that packet are ignored.
- R9: At most `PKT_BYTES` bytes of a packet, counting the opcode, are interpreted. Later bytes without `in_first` are ignored.
- R10: A byte with `in_first` high always starts a new packet, even while the previous packet is still being interpreted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Stream byte present |
| in_first | input | 1 | Byte is the first of a packet |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Byte can be accepted this cycle |
| in_pins | input | 2 | Input-only pins D7 (bit 1) and D6 (bit 0) |
| pin_out | output | 6 | Output levels of pins D5..D0 |
| pin_oe | output | 6 | Output enables of pins D5..D0 |
| rsp_valid | output | 1 | Response byte present (one cycle) |
| rsp_data | output | 8 | Sampled pin levels |

## Verification
The properties assume that `in_data` is stable while `in_valid` is waiting for `in_ready`. They also assume that the response stream is never stalled, because the block has no response back-pressure. The stimulus task keeps a byte on the bus until the cycle it is taken, and the monitor consumes every response in the cycle it appears. The bench uses a short slot, a short microsecond and an 8-byte packet, so that the stall lengths and the packet limit are reached within a few cycles.

// File: rtl/gseq_pkg.sv
// Shared constants and types for the pin sequence interpreter.
// Assumes sub-command classes are decided by the top bits of each byte.
package gseq_pkg;

    localparam logic [7:0] STREAM_OPCODE = 8'hAB;

    typedef enum logic [1:0] {
        FR_IDLE,   // waiting for a packet start
        FR_LIVE,   // interpreting sub-commands
        FR_DROP    // ignoring the rest of the packet
    } fr_state_e;

    typedef enum logic [2:0] {
        SC_READ,
        SC_END,
        SC_DIR,
        SC_LVL,
        SC_WAIT
    } subcmd_e;

    // Classify a sub-command byte by its top bits.
    function automatic subcmd_e classify(input logic [7:0] b);
        case (b[7:6])
            2'b10:   return SC_LVL;
            2'b01:   return SC_DIR;
            2'b11:   return SC_WAIT;
            default: return b[5] ? SC_END : SC_READ;
        endcase
    endfunction

endpackage

// File: rtl/gseq_framer.sv
// Packet framing: decides which accepted bytes are live sub-commands.
// Assumes acc is high only for bytes actually taken from the stream.
module gseq_framer
    import gseq_pkg::*;
#(
    parameter int PKT_BYTES = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc,
    input  logic       first,
    input  logic [7:0] data,
    output logic       cmd_en
);
    localparam int IW = $clog2(PKT_BYTES);
    localparam logic [IW-1:0] LAST_IDX = IW'(PKT_BYTES - 1);

    fr_state_e     st;
    logic [IW-1:0] idx;

    // A live sub-command is any accepted non-start byte while interpreting.
    assign cmd_en = acc && !first && (st == FR_LIVE);

    // Track packet state and the byte position within the packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= FR_IDLE;
            idx <= '0;
        end else if (acc) begin
            if (first) begin
                st  <= (data == STREAM_OPCODE) ? FR_LIVE : FR_DROP;
                idx <= IW'(1);
            end else if (st == FR_LIVE) begin
                if (classify(data) == SC_END || idx == LAST_IDX)
                    st <= FR_DROP;
                idx <= idx + IW'(1);
            end
        end
    end
endmodule

// File: rtl/gseq_wait.sv
// Down-counter that stalls the input stream for a loaded number of cycles.
// Assumes load is only raised when the counter is already zero.
module gseq_wait #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          busy
);
    logic [CW-1:0] cnt;

    assign busy = (cnt != '0);

    // Load the remaining stall length, then count it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (busy)
            cnt <= cnt - CW'(1);
    end
endmodule

// File: rtl/gseq_pins.sv
// Output level and enable registers, plus the pin sampling response.
// Assumes the write strobes are mutually exclusive.
module gseq_pins #(
    parameter int NOUT = 6,
    parameter int NIN  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lvl_we,
    input  logic                oe_we,
    input  logic                rd_en,
    input  logic [NOUT-1:0]     wdata,
    input  logic [NIN-1:0]      in_pins,
    output logic [NOUT-1:0]     pin_out,
    output logic [NOUT-1:0]     pin_oe,
    output logic                rsp_valid,
    output logic [NIN+NOUT-1:0] rsp_data
);
    // Hold the output levels and enables written by sub-commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_out <= '0;
            pin_oe  <= '0;
        end else begin
            if (lvl_we) pin_out <= wdata;
            if (oe_we)  pin_oe  <= wdata;
        end
    end

    // Capture all pin levels into a one-cycle response on a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= rd_en;
            if (rd_en) rsp_data <= {in_pins, pin_out};
        end
    end
endmodule

// File: rtl/gseq_interp.sv
// Top level: decodes pin-control sub-commands from a packetised byte stream.
// Assumes in_data is held while in_valid waits for in_ready, and that the
// response stream is always consumed.
module gseq_interp
    import gseq_pkg::*;
#(
    parameter int SLOT_CLKS   = 150,
    parameter int CLKS_PER_US = 200,
    parameter int PKT_BYTES   = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_first,
    input  logic [7:0] in_data,
    output logic       in_ready,
    input  logic [1:0] in_pins,
    output logic [5:0] pin_out,
    output logic [5:0] pin_oe,
    output logic       rsp_valid,
    output logic [7:0] rsp_data
);
    localparam int MAX_WAIT = 63 * CLKS_PER_US;
    localparam int CW = $clog2((MAX_WAIT > SLOT_CLKS ? MAX_WAIT : SLOT_CLKS) + 1);
    localparam logic [CW-1:0] SLOT_LOAD = CW'(SLOT_CLKS - 1);
    localparam logic [CW-1:0] US_C      = CW'(CLKS_PER_US);

    logic          acc, cmd_en, busy;
    subcmd_e       kind;
    logic          lvl_we, oe_we, rd_en, dly_go;
    logic [CW-1:0] dly_len, load_val;

    assign acc      = in_valid && in_ready;
    assign in_ready = !busy;

    gseq_framer #(.PKT_BYTES(PKT_BYTES)) u_framer (
        .clk    (clk),
        .rst_n  (rst_n),
        .acc    (acc),
        .first  (in_first),
        .data   (in_data),
        .cmd_en (cmd_en)
    );

    // Decode the live sub-command into strobes and a stall length.
    always_comb begin
        kind     = classify(in_data);
        lvl_we   = cmd_en && (kind == SC_LVL);
        oe_we    = cmd_en && (kind == SC_DIR);
        rd_en    = cmd_en && (kind == SC_READ);
        dly_go   = cmd_en && (kind == SC_WAIT) && (in_data[5:0] != 6'd0);
        dly_len  = CW'(in_data[5:0]) * US_C - CW'(1);
        load_val = lvl_we ? SLOT_LOAD : dly_len;
    end

    gseq_wait #(.CW(CW)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (lvl_we || dly_go),
        .load_val (load_val),
        .busy     (busy)
    );

    gseq_pins #(.NOUT(6), .NIN(2)) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_we    (lvl_we),
        .oe_we     (oe_we),
        .rd_en     (rd_en),
        .wdata     (in_data[5:0]),
        .in_pins   (in_pins),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );
endmodule

// File: rtl/gseq_interp_chk.sv
// Property checker for gseq_interp, attached with bind.
module gseq_interp_chk #(
    parameter int SLOT_CLKS = 150
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ready,
    input logic [7:0] in_data,
    input logic [5:0] pin_out,
    input logic [5:0] pin_oe,
    input logic       rsp_valid,
    input logic       cmd_en
);
    // R3
    lvl_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_en && in_data[7:6] == 2'b10) |=> (pin_out == $past(in_data[5:0])));

    // R3
    lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pin_out) |-> $past(cmd_en && in_data[7:6] == 2'b10));

    // R4
    slot_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((SLOT_CLKS > 1) && cmd_en && in_data[7:6] == 2'b10) |=> !in_ready);

    // R5
    oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pin_oe) |-> $past(cmd_en && in_data[7:6] == 2'b01));

    // R7
    rsp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(cmd_en && in_data[7:5] == 3'b000));

    // R7
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid || $past(cmd_en));
endmodule

bind gseq_interp gseq_interp_chk #(.SLOT_CLKS(SLOT_CLKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .rsp_valid (rsp_valid),
    .cmd_en    (cmd_en)
);

// File: tb/test_gseq_interp.sv
// Scoreboard bench: the driver queues expected responses, a monitor checks them.
module test_gseq_interp;
    localparam int SLOT = 4;
    localparam int USC  = 3;
    localparam int PKT  = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_first = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic [1:0] in_pins = 2'b00;
    logic       in_ready, rsp_valid;
    logic [5:0] pin_out, pin_oe;
    logic [7:0] rsp_data;

    int tests = 0, fails = 0, nrsp = 0;
    bit done = 1'b0;
    logic [7:0] expq[$];

    always #2.5 clk = ~clk;

    gseq_interp #(.SLOT_CLKS(SLOT), .CLKS_PER_US(USC), .PKT_BYTES(PKT)) i_gseq_interp (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
        .in_data(in_data), .in_ready(in_ready), .in_pins(in_pins),
        .pin_out(pin_out), .pin_oe(pin_oe), .rsp_valid(rsp_valid), .rsp_data(rsp_data));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Present one byte and return at the falling edge after it was taken.
    task automatic put(input logic [7:0] b, input logic f);
        in_data = b; in_first = f; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b0;
    endtask

    // Count the cycles in_ready stays low after the last accepted byte.
    task automatic stall(output int n);
        n = 0;
        while (!in_ready && n < 1000) begin @(negedge clk); n++; end
    endtask

    // Read sub-command with its expected response queued.
    task automatic rd(input logic [5:0] exp_out);
        expq.push_back({in_pins, exp_out});
        put(8'h00, 1'b0);
    endtask

    // Monitor: every response must match the head of the queue (R7).
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            nrsp++;
            if (expq.size() == 0) chk(1'b0, "R7 unexpected response", rsp_data, 0);
            else begin
                logic [7:0] e;
                e = expq.pop_front();
                chk(rsp_data == e, "R7 response data", rsp_data, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1 reset values
        chk(pin_out == 6'h00, "R1 pin_out", pin_out, 0);
        chk(pin_oe == 6'h00, "R1 pin_oe", pin_oe, 0);
        chk(!rsp_valid, "R1 rsp_valid", rsp_valid, 0);
        chk(in_ready, "R1 in_ready", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // Main program: enables, levels, read, waits, end marker
        in_pins = 2'b10;
        put(8'hAB, 1'b1);
        put(8'h7F, 1'b0);
        chk(pin_oe == 6'h3F, "R5 enable write", pin_oe, 6'h3F);
        chk(in_ready, "R5 no stall", in_ready, 1);
        put(8'hB7, 1'b0);
        chk(pin_out == 6'h37, "R3 level write", pin_out, 6'h37);
        stall(n);
        chk(n == SLOT - 1, "R4 slot stall", n, SLOT - 1);
        rd(6'h37);
        put(8'hC5, 1'b0);
        stall(n);
        chk(n == 5 * USC - 1, "R6 wait 5us", n, 5 * USC - 1);
        put(8'hC0, 1'b0);
        stall(n);
        chk(n == 0, "R6 wait zero", n, 0);
        put(8'hB6, 1'b0);
        stall(n);
        chk(pin_out == 6'h36, "R3 assert select", pin_out, 6'h36);
        put(8'h20, 1'b0);
        put(8'h81, 1'b0);
        put(8'h00, 1'b0);
        chk(pin_out == 6'h36, "R8 bytes after end ignored", pin_out, 6'h36);

        // R4 back-to-back level writes: one update per slot
        put(8'hAB, 1'b1);
        put(8'h81, 1'b0);
        stall(n);
        chk(n == SLOT - 1, "R4 first slot", n, SLOT - 1);
        put(8'h82, 1'b0);
        chk(pin_out == 6'h02, "R4 second slot level", pin_out, 6'h02);
        stall(n);
        chk(n == SLOT - 1, "R4 second slot", n, SLOT - 1);

        // R2 packet with wrong opcode discarded
        put(8'h55, 1'b1);
        put(8'h8A, 1'b0);
        put(8'h40, 1'b0);
        put(8'h00, 1'b0);
        chk(pin_out == 6'h02, "R2 levels untouched", pin_out, 6'h02);
        chk(pin_oe == 6'h3F, "R2 enables untouched", pin_oe, 6'h3F);

        // R10 new packet start interrupts a live packet
        put(8'hAB, 1'b1);
        put(8'h84, 1'b0);
        stall(n);
        put(8'h11, 1'b1);
        put(8'h85, 1'b0);
        chk(pin_out == 6'h04, "R10 restart discards", pin_out, 6'h04);
        put(8'hAB, 1'b1);
        put(8'h40, 1'b0);
        chk(pin_oe == 6'h00, "R10 restart live", pin_oe, 0);

        // R9 packet length limit
        put(8'hAB, 1'b1);
        for (int i = 0; i < PKT - 2; i++) put(8'h41, 1'b0);
        put(8'h83, 1'b0);
        stall(n);
        chk(pin_out == 6'h03, "R9 last byte executes", pin_out, 6'h03);
        put(8'h8C, 1'b0);
        put(8'h00, 1'b0);
        chk(pin_out == 6'h03, "R9 overflow ignored", pin_out, 6'h03);
        chk(pin_oe == 6'h01, "R9 enables", pin_oe, 6'h01);

        // R7 read with other input pattern
        in_pins = 2'b01;
        put(8'hAB, 1'b1);
        rd(6'h03);
        repeat (4) @(negedge clk);
        chk(expq.size() == 0, "R7 all responses seen", expq.size(), 0);
        chk(nrsp == 2, "R7 response count", nrsp, 2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule